// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable stand-in for a small serial EEPROM. A host drives a chip select, a serial clock and a serial data line, and it reads a serial data line back. All three inputs are sampled by a fast system clock through synchronizers, and the serial clock is recovered as a rising-edge pulse. Each framed instruction is decoded against an internal byte array. Reads return a word. Write and erase change one word. The bulk forms change every word. Two further instructions open and close the programming latch.

A strap input selects the word width. With the strap high, words are 16 bits wide and the address is one bit shorter. With it low, words are 8 bits wide. Every programming operation starts a self-timed busy period that lasts a parameterized number of system clocks. While that period runs, the host can deselect and then reselect the part to watch a busy/ready level on the data output. The output-enable pin stands in for a tri-state data pin.

Top module: `eep3w_slave`

## Requirements
- R1: An instruction starts with the first serial clock rise that sees data high while chip select is high. Rises that see data low before that start bit are ignored. Dropping chip select abandons any instruction that is not yet complete.
- R2: After the start bit, two opcode bits follow, MSB first: 10 = read, 01 = write, 11 = erase. Opcode 00 is decoded by the two most significant address bits: 11 = enable programming, 00 = disable programming, 10 = erase all, 01 = write all.
- R3: With org16_i high, the address is ADDR16_W bits and a word is 16 bits. With it low, the address is ADDR16_W+1 bits and a word is 8 bits. The 16-bit word at address a is made of byte 2a (low half) and byte 2a+1 (high half) in the 8-bit view.
- R4: After the last address bit of a read, DO shows a single 0, then the addressed word MSB first. The output changes only after serial clock rises.
- R5: After reset, programming is disabled. Write, erase, write-all and erase-all change nothing and start no busy period until an enable instruction has completed.
- R6: A read returns the stored data whether programming is enabled or disabled.
- R7: Erase sets every bit of the addressed word to 1. A write replaces the word directly, with no erase needed first.
- R8: Write-all stores the supplied data in every word. Erase-all sets every bit of the array to 1.
- R9: If chip select drops and then rises again while a busy period runs, DO is driven 0 while busy and turns 1 when the period ends. A chip-select rise after the period has ended presents no status.
- R10: The don't-care address bits of the enable, disable and bulk instructions, and all data bits of a write, must be clocked in. An instruction cut short by chip select has no effect.
- R11: The busy period lasts PROG_CYCLES system clocks. It starts after the last data bit (or the last address bit for erase forms). Instructions sent while busy are ignored.
- R12: do_oe_o is high only while chip select is high and a read or status phase is active.
- R13: After reset, every byte of the array reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock; input data is taken on its rising edge |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | Organization strap: 1 = 16-bit words, 0 = 8-bit words |
| do_o | output | 1 | Serial data out: read data or busy/ready level |
| do_oe_o | output | 1 | Output enable for DO; low models high impedance |

## Verification
The busy period can end while a status phase is being shown. In that case the busy counter reaching zero and the status driver switch DO in the same stretch of cycles. The bench provokes this by reselecting the part soon after a write and then holding chip select high across the end of the period. It judges the result by seeing DO at 0 first and at 1 afterwards, while the output enable stays high throughout. It also sends a second write in the middle of a busy period and confirms, by reading back, that the second write left no trace.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_READ,
      ST_DONE,
      ST_STAT
   } eep_state_t;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_ERASE = 2'b11;
   localparam logic [1:0] OPC_EXT   = 2'b00;

   localparam logic [1:0] SUB_EN    = 2'b11;
   localparam logic [1:0] SUB_DIS   = 2'b00;
   localparam logic [1:0] SUB_ERALL = 2'b10;
   localparam logic [1:0] SUB_WRALL = 2'b01;

endpackage

// File: rtl/eep3w_sync.sv
module eep3w_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eep3w_sync: STAGES must be at least 2");
   end

   logic [N-1:0] pipe_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      end else begin
         pipe_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/eep3w_array.sv
module eep3w_array #(
   parameter int BYTE_AW = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               we_i,
   input  logic               all_i,
   input  logic               wide_i,
   input  logic [BYTE_AW-1:0] waddr_i,
   input  logic [15:0]        wdata_i,
   input  logic [BYTE_AW-1:0] raddr_i,
   output logic [15:0]        rdata_o
);
   localparam int NBYTES = 1 << BYTE_AW;

   logic [NBYTES*8-1:0] flat;

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      localparam logic [BYTE_AW-1:0] IDX = BYTE_AW'(g);
      logic [7:0] byte_q;
      logic       hit;

      assign hit = we_i && (wide_i ? (waddr_i[BYTE_AW-1:1] == IDX[BYTE_AW-1:1])
                                   : (waddr_i == IDX));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)             byte_q <= 8'hFF;
         else if (all_i || hit)   byte_q <= IDX[0] ? wdata_i[15:8] : wdata_i[7:0];
      end

      assign flat[g*8 +: 8] = byte_q;
   end

   logic [BYTE_AW-1:0] ra_lo, ra_hi;
   assign ra_lo = {raddr_i[BYTE_AW-1:1], 1'b0};
   assign ra_hi = {raddr_i[BYTE_AW-1:1], 1'b1};

   assign rdata_o = wide_i ? {flat[ra_hi*8 +: 8], flat[ra_lo*8 +: 8]}
                           : {flat[raddr_i*8 +: 8], 8'h00};
endmodule

// File: rtl/eep3w_timer.sv
module eep3w_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("eep3w_timer: CYCLES must be at least 1");
   end

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         busy_o <= 1'b0;
      end else if (start_i && !busy_o) begin
         cnt_q  <= CW'(CYCLES - 1);
         busy_o <= 1'b1;
      end else if (busy_o) begin
         if (cnt_q == '0) busy_o <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave
   import eep3w_pkg::*;
#(
   parameter int ADDR16_W    = 6,
   parameter int PROG_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   input  logic org16_i,
   output logic do_o,
   output logic do_oe_o
);
   localparam int AW8     = ADDR16_W + 1;
   localparam int HDR_MAX = AW8 + 2;
   localparam int CW      = $clog2((HDR_MAX > 16 ? HDR_MAX : 16) + 1);

   if (ADDR16_W < 2) begin : g_bad_aw
      $error("eep3w_slave: ADDR16_W must be at least 2");
   end

   // input sampling and edge recovery
   logic cs_s, sk_s, di_s, cs_d, sk_d, cs_rise, sk_rise;

   eep3w_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({cs_i, sk_i, di_i}),
      .q_o   ({cs_s, sk_s, di_s})
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_d <= 1'b0;
         sk_d <= 1'b0;
      end else begin
         cs_d <= cs_s;
         sk_d <= sk_s;
      end
   end

   assign cs_rise = cs_s & ~cs_d;
   assign sk_rise = sk_s & ~sk_d;

   // state
   eep_state_t         state_q;
   logic [CW-1:0]      cnt_q;
   logic [HDR_MAX-1:0] hdr_q;
   logic [15:0]        dat_q, sh_q;
   logic [AW8-1:0]     pg_addr_q;
   logic               pg_all_q, wen_q, do_q, busy;

   // header decode, taken from the shifted value including the current bit
   logic [HDR_MAX-1:0] hdr_nx;
   logic [1:0]         opc, sub;
   logic [AW8-1:0]     byte_addr;
   logic [CW-1:0]      hdr_last, word_last, rd_len;
   logic [15:0]        dat_nx, wr_data, rdata;
   logic               hdr_done, dat_done;

   assign hdr_nx    = {hdr_q[HDR_MAX-2:0], di_s};
   assign opc       = org16_i ? hdr_nx[ADDR16_W+1 -: 2] : hdr_nx[AW8+1 -: 2];
   assign sub       = org16_i ? hdr_nx[ADDR16_W-1 -: 2] : hdr_nx[AW8-1 -: 2];
   assign byte_addr = org16_i ? {hdr_nx[ADDR16_W-1:0], 1'b0} : hdr_nx[AW8-1:0];
   assign hdr_last  = org16_i ? CW'(ADDR16_W + 1) : CW'(AW8 + 1);
   assign word_last = org16_i ? CW'(15) : CW'(7);
   assign rd_len    = org16_i ? CW'(16) : CW'(8);
   assign dat_nx    = {dat_q[14:0], di_s};
   assign wr_data   = org16_i ? dat_nx : {dat_nx[7:0], dat_nx[7:0]};

   assign hdr_done = cs_s && sk_rise && (state_q == ST_HDR)  && (cnt_q == hdr_last);
   assign dat_done = cs_s && sk_rise && (state_q == ST_DATA) && (cnt_q == word_last);

   // programming request
   logic req, req_all, req_erase, prog_go;
   logic arr_we, arr_all;
   logic [AW8-1:0] arr_waddr;
   logic [15:0]    arr_wdata;

   always_comb begin
      req       = 1'b0;
      req_all   = 1'b0;
      req_erase = 1'b0;
      if (hdr_done && opc == OPC_ERASE) begin
         req       = 1'b1;
         req_erase = 1'b1;
      end
      if (hdr_done && opc == OPC_EXT && sub == SUB_ERALL) begin
         req       = 1'b1;
         req_all   = 1'b1;
         req_erase = 1'b1;
      end
      if (dat_done) begin
         req     = 1'b1;
         req_all = pg_all_q;
      end
   end

   assign prog_go   = req & wen_q;
   assign arr_we    = prog_go & ~req_all;
   assign arr_all   = prog_go & req_all;
   assign arr_waddr = dat_done ? pg_addr_q : byte_addr;
   assign arr_wdata = req_erase ? 16'hFFFF : wr_data;

   eep3w_array #(.BYTE_AW(AW8)) u_array (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (arr_we),
      .all_i  (arr_all),
      .wide_i (org16_i),
      .waddr_i(arr_waddr),
      .wdata_i(arr_wdata),
      .raddr_i(byte_addr),
      .rdata_o(rdata)
   );

   eep3w_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(prog_go),
      .busy_o (busy)
   );

   // instruction sequencer
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         hdr_q     <= '0;
         dat_q     <= '0;
         sh_q      <= '0;
         pg_addr_q <= '0;
         pg_all_q  <= 1'b0;
         wen_q     <= 1'b0;
         do_q      <= 1'b1;
      end else begin
         if (state_q != ST_READ) do_q <= ~busy;
         if (!cs_s) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (busy) begin
                     state_q <= cs_rise ? ST_STAT : ST_DONE;
                  end else if (sk_rise && di_s) begin
                     state_q <= ST_HDR;
                     cnt_q   <= '0;
                  end
               end
               ST_HDR: begin
                  if (sk_rise) begin
                     hdr_q <= hdr_nx;
                     cnt_q <= cnt_q + 1'b1;
                     if (hdr_done) begin
                        cnt_q   <= '0;
                        state_q <= ST_DONE;
                        unique case (opc)
                           OPC_READ: begin
                              state_q <= ST_READ;
                              sh_q    <= rdata;
                              do_q    <= 1'b0;
                           end
                           OPC_WRITE: begin
                              state_q   <= ST_DATA;
                              pg_addr_q <= byte_addr;
                              pg_all_q  <= 1'b0;
                           end
                           OPC_ERASE: ;
                           OPC_EXT: begin
                              unique case (sub)
                                 SUB_EN:    wen_q <= 1'b1;
                                 SUB_DIS:   wen_q <= 1'b0;
                                 SUB_WRALL: begin
                                    state_q  <= ST_DATA;
                                    pg_all_q <= 1'b1;
                                 end
                                 SUB_ERALL: ;
                              endcase
                           end
                        endcase
                     end
                  end
               end
               ST_DATA: begin
                  if (sk_rise) begin
                     dat_q <= dat_nx;
                     cnt_q <= cnt_q + 1'b1;
                     if (dat_done) state_q <= ST_DONE;
                  end
               end
               ST_READ: begin
                  if (sk_rise) begin
                     if (cnt_q == rd_len) begin
                        state_q <= ST_DONE;
                     end else begin
                        do_q  <= sh_q[15];
                        sh_q  <= {sh_q[14:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_DONE, ST_STAT: ;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign do_o    = do_q;
   assign do_oe_o = (state_q == ST_READ) || (state_q == ST_STAT);
endmodule

// File: rtl/eep3w_slave_chk.sv
module eep3w_slave_chk
   import eep3w_pkg::*;
(
   input logic       clk_i,
   input logic       rst_ni,
   input logic       cs_s,
   input eep_state_t state_q,
   input logic       do_o,
   input logic       do_oe_o,
   input logic       busy,
   input logic       wen_q,
   input logic       prog_go
);
   AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_s |=> !do_oe_o); // R12

   AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy) |-> wen_q); // R5

   AST_READ_DUMMY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_READ && $past(state_q) != ST_READ) |-> !do_o); // R4

   AST_READY_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(busy) && state_q != ST_READ) |=> do_o); // R9

   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prog_go |-> !busy); // R11
endmodule

bind eep3w_slave eep3w_slave_chk u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .cs_s   (cs_s),
   .state_q(state_q),
   .do_o   (do_o),
   .do_oe_o(do_oe_o),
   .busy   (busy),
   .wen_q  (wen_q),
   .prog_go(prog_go)
);

// File: tb/tb_eep3w_slave.sv
module tb_eep3w_slave;
   localparam int AW16 = 6;
   localparam int PROG = 400;
   localparam int H    = 4;
   localparam int NB   = 1 << (AW16 + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
   logic do_o, do_oe;

   always #10 clk = ~clk;

   eep3w_slave #(.ADDR16_W(AW16), .PROG_CYCLES(PROG)) dut (
      .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
      .org16_i(org), .do_o(do_o), .do_oe_o(do_oe)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   longint cyc = 0;
   longint busy_until = 0;
   logic [7:0] ref_mem [NB];
   bit ref_wen = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // R12: output enable must be low once chip select has been low for a while
   int cs_low = 0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (!cs) cs_low++; else cs_low = 0;
         if (cs_low >= 5) check("R12", {31'd0, do_oe}, 32'd0, "oe with cs low");
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sk_bit(input logic d, output logic so, output logic soe);
      di = d;
      tick(H);
      so  = do_o;
      soe = do_oe;
      sk = 1'b1;
      tick(H);
      sk = 1'b0;
   endtask

   task automatic send(input logic [31:0] v, input int n);
      logic so, soe;
      for (int i = n - 1; i >= 0; i--) sk_bit(v[i], so, soe);
   endtask

   task automatic cs_on();  cs = 1'b1; sk = 1'b0; tick(H); endtask
   task automatic cs_off(); cs = 1'b0; di = 1'b0; tick(H); endtask

   function automatic int naddr(); return org ? AW16 : AW16 + 1; endfunction
   function automatic int nword(); return org ? 16 : 8; endfunction
   function automatic bit busy_now(); return cyc < busy_until; endfunction

   function automatic logic [15:0] ref_word(input int a);
      return org ? {ref_mem[2*a+1], ref_mem[2*a]} : {8'h00, ref_mem[a]};
   endfunction

   function automatic void ref_store(input int a, input logic [15:0] d);
      if (org) begin ref_mem[2*a] = d[7:0]; ref_mem[2*a+1] = d[15:8]; end
      else ref_mem[a] = d[7:0];
   endfunction

   function automatic bit prog_ok();
      bit ok = ref_wen && !busy_now();
      if (ok) busy_until = cyc + PROG + 20;
      return ok;
   endfunction

   task automatic wait_prog(); tick(PROG + 40); endtask

   task automatic op_write(input int a, input logic [15:0] d);
      bit ok = !busy_now();
      cs_on(); send(3'b101, 3); send(a, naddr()); send(d, nword()); cs_off();
      if (ok && prog_ok()) ref_store(a, d);
   endtask

   task automatic op_erase(input int a);
      cs_on(); send(3'b111, 3); send(a, naddr()); cs_off();
      if (prog_ok()) ref_store(a, 16'hFFFF);
   endtask

   task automatic op_ext(input logic [1:0] sb, input logic [15:0] d);
      cs_on(); send(3'b100, 3); send(sb, 2); send(0, naddr() - 2);
      if (sb == 2'b01) send(d, nword());
      cs_off();
      if (sb == 2'b11) ref_wen = 1'b1;
      else if (sb == 2'b00) ref_wen = 1'b0;
      else if (prog_ok()) begin
         for (int i = 0; i < NB; i++)
            ref_mem[i] = (sb == 2'b10) ? 8'hFF : (org ? (i[0] ? d[15:8] : d[7:0]) : d[7:0]);
      end
   endtask

   task automatic op_read(input string req, input int a, input int lead0);
      logic so, soe;
      logic [15:0] got = '0;
      logic [15:0] exp = ref_word(a);
      cs_on();
      send(0, lead0);
      send(3'b110, 3); send(a, naddr());
      sk_bit(1'b0, so, soe);
      check("R4", {30'd0, soe, so}, 32'd2, "dummy bit and enable");
      for (int i = 0; i < nword(); i++) begin
         sk_bit(1'b0, so, soe);
         got = {got[14:0], so};
      end
      cs_off();
      check(req, {16'd0, got}, {16'd0, exp}, $sformatf("read addr %0d", a));
   endtask

   initial begin
      tick(150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NB; i++) ref_mem[i] = 8'hFF;
      tick(10);
      rst_n = 1'b1;
      tick(4);
      check("R12", {31'd0, do_oe}, 32'd0, "oe after reset");

      // R13: erased after reset
      org = 1'b1; op_read("R13", 0, 0);
      org = 1'b0; op_read("R13", NB - 1, 0);

      // R5: programming locked after reset, no busy period
      org = 1'b1; op_write(5, 16'hA55A);
      cs_on(); tick(6);
      check("R5", {31'd0, do_oe}, 32'd0, "no status while locked");
      cs_off();
      op_read("R5", 5, 0);

      // R2 enable, then write with status watching (R9)
      op_ext(2'b11, 0);
      op_write(5, 16'hA55A);
      cs_on(); tick(6);
      check("R9", {30'd0, do_oe, do_o}, 32'd2, "busy status");
      tick(PROG);
      check("R9", {30'd0, do_oe, do_o}, 32'd3, "ready with cs held");
      cs_off();
      cs_on(); tick(6);
      check("R9", {31'd0, do_oe}, 32'd0, "no status after end");
      cs_off();
      op_read("R4", 5, 0);

      // R3: organization and byte mapping
      org = 1'b0; op_read("R3", 10, 0); op_read("R3", 11, 0);
      op_write(20, 16'h003C); wait_prog();
      op_read("R3", 20, 0);
      org = 1'b1; op_read("R3", 10, 0);

      // R7: erase and direct overwrite
      op_erase(5); wait_prog(); op_read("R7", 5, 0);
      op_write(7, 16'h1234); wait_prog();
      op_write(7, 16'hABCD); wait_prog(); op_read("R7", 7, 0);
      org = 1'b0; op_erase(14); wait_prog();
      org = 1'b1; op_read("R7", 7, 0);

      // R11: second write during busy is ignored; busy length
      op_write(8, 16'h1111);
      op_write(9, 16'h2222);
      cs_on(); tick(6);
      check("R11", {30'd0, do_oe, do_o}, 32'd2, "still busy");
      tick(200);
      check("R11", {30'd0, do_oe, do_o}, 32'd3, "ready after period");
      cs_off();
      op_read("R11", 8, 0); op_read("R11", 9, 0);

      // R10: truncated disable and truncated write have no effect
      cs_on(); send(5'b10000, 5); send(0, 2); cs_off();
      op_write(12, 16'hBEEF); wait_prog(); op_read("R10", 12, 0);
      cs_on(); send(3'b101, 3); send(13, naddr()); send(10'h155, 10); cs_off();
      wait_prog(); op_read("R10", 13, 0);

      // R8: bulk forms in both organizations
      op_ext(2'b01, 16'h5AA5); wait_prog();
      op_read("R8", 0, 0); op_read("R8", 33, 0); op_read("R8", 63, 0);
      org = 1'b0; op_ext(2'b01, 16'h0077); wait_prog();
      org = 1'b1; op_read("R8", 20, 0);
      op_ext(2'b10, 0); wait_prog();
      op_read("R8", 0, 0); op_read("R8", 63, 0);
      org = 1'b0; op_read("R8", 5, 0);

      // R6: disabled, write ignored, read still works
      org = 1'b1; op_write(3, 16'h5A5A); wait_prog();
      op_ext(2'b00, 0);
      op_write(3, 16'h0F0F); wait_prog();
      op_read("R6", 3, 0);

      // R1: leading zeros before the start bit
      op_read("R1", 3, 3);
      org = 1'b0; op_read("R1", 7, 2);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule